// File: doc/BRIEF.md
# Smart-card UART with parity-error signalling

This block is a half-duplex asynchronous serial transceiver for a subscriber-identity-card link. Its transmitter and receiver share one open-drain line. The block drives that line through a pull-down enable, `line_pd_o`, and senses the resulting level on `line_i`. Each character is 8 bits with even parity. The bit time is set by a divider value `div_i`: one bit lasts 16 × (`div_i` + 1) clock cycles.

Either end of the link can reject a character that arrives with bad parity. It does so by holding the line low through that character's stop slot. The receiver here does this when it sees a parity error. The transmitter reads the line in the middle of its own stop slot to learn whether the far end rejected the character. Software writes one byte into a holding register and reads received bytes from a data register. It watches ready, idle, valid, error and rejection flags, plus two single-cycle interrupt pulses.

Top module: `scu_uart`

## Requirements
- R1: A transmitted frame occupies 11 slots of 16 × (`div_i` + 1) cycles each. The slots are a start slot (line pulled low), 8 data slots with the least significant bit first, one parity slot and one stop slot in which the line is released. `line_pd_o` is high exactly in slots that carry a 0. A frame begins on the clock edge after the write is taken, provided the transmitter and receiver are both idle.
- R2: The parity slot carries the bit that makes the total number of ones across the 8 data bits and the parity bit even.
- R3: A write is taken only while `tx_ready_o` is 1 (holding register empty). A write while the register is full is dropped. A pending byte starts on the edge after the current frame ends. `tx_idle_o` is 1 exactly when nothing is held and nothing is being shifted.
- R4: `tx_irq_o` is high for one cycle, starting at the edge that ends the stop slot, which is 11 bit times after the frame start.
- R5: The transmitter samples the line at the middle of its stop slot. A low reading sets `nack_o`, which stays set until `nack_clr_i` is 1 at an edge. A new low reading at the same edge wins over the clear.
- R6: `line_i` passes two synchronising flops. A start is recognised 2 edges after the first edge at which `line_i` is low, provided it was high before. The receiver samples 8 × (`div_i` + 1) cycles after recognition and every bit time after that. A high level at the start sample abandons the character without any output.
- R7: 11 bit times after recognition, the byte (first received bit in bit 0) appears on `rx_data_o`. At the same edge `rx_valid_o` is set and `rx_irq_o` pulses for one cycle. `rx_ack_i` clears `rx_valid_o`, and a new byte wins over the clear.
- R8: If the received parity is wrong, `rx_perr_o` is 1 with that byte. The block also pulls the line low from 10 to 11 bit times after recognition. With correct parity there is no pull-down and `rx_perr_o` is 0.
- R9: While the transmitter is active the receiver ignores the line, so the block never receives its own character. A write made during reception is held and sent after the received character completes.
- R10: During reset `line_pd_o`, `tx_irq_o`, `nack_o`, `rx_valid_o`, `rx_perr_o` and `rx_irq_o` are 0, `rx_data_o` is 0, and `tx_ready_o` and `tx_idle_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the divider count source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Divider value n; bit time is 16(n+1) cycles |
| tx_data_i | input | 8 | Byte to send |
| tx_we_i | input | 1 | Write strobe for the holding register |
| tx_ready_o | output | 1 | Holding register empty |
| tx_idle_o | output | 1 | Nothing held and nothing shifting |
| tx_irq_o | output | 1 | Pulse at end of a transmitted character |
| nack_o | output | 1 | Sticky: far end rejected a character |
| nack_clr_i | input | 1 | Clears `nack_o` |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | Received byte not yet acknowledged |
| rx_ack_i | input | 1 | Acknowledge (read) of `rx_data_o` |
| rx_perr_o | output | 1 | Parity of the last received byte was wrong |
| rx_irq_o | output | 1 | Pulse when a byte is received |
| line_i | input | 1 | Sensed level of the shared line |
| line_pd_o | output | 1 | Pull-down enable for the shared line |

## Verification
Two situations are the hardest to reach from the ports. The first is a rejection that lands exactly in the transmitter's stop slot. The bench's card model counts cycles from the accepted write and pulls the shared line low for most of that slot. The second is the collision between a local write and an incoming character. To create it, the card model starts a frame and the bench issues a write part-way through it. A cycle-level reference then confirms that the write waits, and that the receiver never picks up the block's own traffic once the held byte goes out.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam int DW        = 8;
  localparam int OSR       = 16;
  localparam int OSR_W     = $clog2(OSR);
  localparam int PAR_SLOT  = DW + 1;
  localparam int STOP_SLOT = DW + 2;
  localparam int SLOT_W    = $clog2(STOP_SLOT + 1);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [DW-1:0]     byte_t;
endpackage

// File: rtl/scu_bitclk.sv
module scu_bitclk
  import scu_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             start_i,
  output slot_t            slot_o,
  output logic             mid_o,
  output logic             bnd_o
);
  logic [DIV_W-1:0] pre_q;
  logic [OSR_W-1:0] tcnt_q;
  slot_t            slot_q;
  logic             tick;

  assign tick   = run_i && (pre_q == div_i);
  assign mid_o  = tick && (tcnt_q == OSR_W'(OSR/2 - 1));
  assign bnd_o  = tick && (tcnt_q == OSR_W'(OSR - 1));
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tcnt_q <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      pre_q  <= '0;
      tcnt_q <= '0;
      slot_q <= '0;
    end else if (run_i) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        tcnt_q <= bnd_o ? '0 : tcnt_q + 1'b1;
        if (bnd_o) slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scu_tx.sv
module scu_tx
  import scu_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  byte_t            data_i,
  input  logic             we_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             line_i,
  output logic             ready_o,
  output logic             idle_o,
  output logic             active_o,
  output logic             irq_o,
  output logic             nack_o,
  output logic             pd_o
);
  logic             hold_full_q, active_q, irq_q, nack_q;
  byte_t            hold_q;
  logic [STOP_SLOT:0] frm_q;
  slot_t            slot;
  logic             mid, bnd, start, done, samp;

  assign start = ~active_q & hold_full_q & ~hold_i;
  assign done  = active_q & bnd & (slot == SLOT_W'(STOP_SLOT));
  assign samp  = active_q & mid & (slot == SLOT_W'(STOP_SLOT));

  scu_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_i),
    .run_i   (active_q),
    .start_i (start),
    .slot_o  (slot),
    .mid_o   (mid),
    .bnd_o   (bnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      active_q    <= 1'b0;
      frm_q       <= '1;
      irq_q       <= 1'b0;
      nack_q      <= 1'b0;
    end else begin
      if (start) begin
        active_q    <= 1'b1;
        frm_q       <= {1'b1, (^hold_q) ^ ODD_PARITY, hold_q, 1'b0};
        hold_full_q <= 1'b0;
      end else if (done) begin
        active_q <= 1'b0;
      end
      if (we_i && !hold_full_q) begin
        hold_full_q <= 1'b1;
        hold_q      <= data_i;
      end
      irq_q <= done;
      if (samp && !line_i) nack_q <= 1'b1;
      else if (clr_i)      nack_q <= 1'b0;
    end
  end

  assign pd_o     = active_q & ~frm_q[slot];
  assign ready_o  = ~hold_full_q;
  assign idle_o   = ~hold_full_q & ~active_q;
  assign active_o = active_q;
  assign irq_o    = irq_q;
  assign nack_o   = nack_q;

  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  a_r3_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && !start && we_i) |=> (hold_full_q && $stable(hold_q)));
  a_r5_nack_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_q && !clr_i) |=> nack_q);
  a_r1_stop_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && slot == SLOT_W'(STOP_SLOT)) |-> !pd_o);
endmodule

// File: rtl/scu_rx.sv
module scu_rx
  import scu_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             line_i,
  input  logic             en_i,
  input  logic             ack_i,
  output byte_t            data_o,
  output logic             valid_o,
  output logic             perr_o,
  output logic             irq_o,
  output logic             pd_o,
  output logic             busy_o
);
  logic  prev_q, active_q, perr_q, valid_q, perr_out_q, irq_q;
  byte_t shr_q, data_q;
  slot_t slot;
  logic  mid, bnd, start, done, samp;

  assign start = ~active_q & en_i & ~line_i & prev_q;
  assign samp  = active_q & mid;
  assign done  = active_q & bnd & (slot == SLOT_W'(STOP_SLOT));

  scu_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_i),
    .run_i   (active_q),
    .start_i (start),
    .slot_o  (slot),
    .mid_o   (mid),
    .bnd_o   (bnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b1;
      active_q   <= 1'b0;
      perr_q     <= 1'b0;
      shr_q      <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
      perr_out_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      prev_q <= line_i;
      irq_q  <= done;
      if (start) begin
        active_q <= 1'b1;
        perr_q   <= 1'b0;
      end else if (samp) begin
        if (slot == '0) begin
          if (line_i) active_q <= 1'b0;  // false start
        end else if (slot <= SLOT_W'(DW)) begin
          shr_q <= {line_i, shr_q[DW-1:1]};
        end else if (slot == SLOT_W'(PAR_SLOT)) begin
          perr_q <= ((^shr_q) ^ line_i) != ODD_PARITY;
        end
      end else if (done) begin
        active_q <= 1'b0;
      end
      if (done) begin
        data_q     <= shr_q;
        perr_out_q <= perr_q;
        valid_q    <= 1'b1;
      end else if (ack_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign pd_o    = active_q & perr_q & (slot == SLOT_W'(STOP_SLOT));
  assign busy_o  = active_q | start;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign perr_o  = perr_out_q;
  assign irq_o   = irq_q;

  a_r7_valid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ack_i) |=> valid_q);
  a_r6_no_start_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !active_q) |=> !active_q);
endmodule

// File: rtl/scu_uart.sv
module scu_uart
  import scu_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_we_i,
  output logic             tx_ready_o,
  output logic             tx_idle_o,
  output logic             tx_irq_o,
  output logic             nack_o,
  input  logic             nack_clr_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ack_i,
  output logic             rx_perr_o,
  output logic             rx_irq_o,
  input  logic             line_i,
  output logic             line_pd_o
);
  logic [1:0] sync_q;
  logic       line_s, tx_active, rx_busy, tx_pd, rx_pd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[0], line_i};
  end
  assign line_s = sync_q[1];

  scu_tx #(.DIV_W(DIV_W), .ODD_PARITY(ODD_PARITY)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_i),
    .data_i   (tx_data_i),
    .we_i     (tx_we_i),
    .clr_i    (nack_clr_i),
    .hold_i   (rx_busy),
    .line_i   (line_s),
    .ready_o  (tx_ready_o),
    .idle_o   (tx_idle_o),
    .active_o (tx_active),
    .irq_o    (tx_irq_o),
    .nack_o   (nack_o),
    .pd_o     (tx_pd)
  );

  scu_rx #(.DIV_W(DIV_W), .ODD_PARITY(ODD_PARITY)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_i),
    .line_i  (line_s),
    .en_i    (~tx_active),
    .ack_i   (rx_ack_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .perr_o  (rx_perr_o),
    .irq_o   (rx_irq_o),
    .pd_o    (rx_pd),
    .busy_o  (rx_busy)
  );

  assign line_pd_o = tx_pd | rx_pd;

  a_r9_half_duplex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_active && rx_busy));
endmodule

// File: tb/scu_uart_tb.sv
module scu_uart_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [7:0] div, tx_data;
  logic       tx_we, nack_clr, rx_ack, card_pd;
  logic       tx_ready, tx_idle, tx_irq, nack, rx_valid, rx_perr, rx_irq, line_pd;
  logic [7:0] rx_data;
  logic       line;
  assign line = ~(line_pd | card_pd);

  int vectors = 0, miscompares = 0, n_txirq = 0, n_rxirq = 0;

  scu_uart u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div),
    .tx_data_i(tx_data), .tx_we_i(tx_we), .tx_ready_o(tx_ready), .tx_idle_o(tx_idle),
    .tx_irq_o(tx_irq), .nack_o(nack), .nack_clr_i(nack_clr),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ack_i(rx_ack), .rx_perr_o(rx_perr),
    .rx_irq_o(rx_irq), .line_i(line), .line_pd_o(line_pd)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // behavioural reference, stepped once per clock
  logic       m_hold_full = 0, m_tx_act = 0, m_rx_act = 0, m_nack = 0;
  logic       m_txirq = 0, m_rxirq = 0, m_valid = 0, m_perr = 0, m_perr_out = 0;
  logic [7:0] m_hold = 0, m_frame = 0, m_bits = 0, m_rdata = 0;
  logic [3:0] lh = 4'hF;
  int         m_t = 0, m_r = 0;

  function automatic logic exp_pd();
    int b, s;
    logic bit_v;
    b = 16 * (int'(div) + 1);
    s = m_t / b;
    if (s == 0)      bit_v = 1'b0;
    else if (s <= 8) bit_v = m_frame[s-1];
    else if (s == 9) bit_v = ^m_frame;
    else             bit_v = 1'b1;
    return (m_tx_act && !bit_v) || (m_rx_act && m_perr && m_r >= 10 * b);
  endfunction

  always @(negedge clk) begin : ref_model
    int b, h, k;
    logic old_tx, old_rx, old_hold, rxs, txs, nset, done_r;
    chk("R1/R8 line_pd_o", {7'd0, line_pd}, {7'd0, exp_pd()});
    chk("R3 tx_ready_o", {7'd0, tx_ready}, {7'd0, !m_hold_full});
    chk("R3 tx_idle_o", {7'd0, tx_idle}, {7'd0, !m_hold_full && !m_tx_act});
    chk("R4 tx_irq_o", {7'd0, tx_irq}, {7'd0, m_txirq});
    chk("R5 nack_o", {7'd0, nack}, {7'd0, m_nack});
    chk("R7 rx_data_o", rx_data, m_rdata);
    chk("R7 rx_valid_o", {7'd0, rx_valid}, {7'd0, m_valid});
    chk("R7 rx_irq_o", {7'd0, rx_irq}, {7'd0, m_rxirq});
    chk("R8 rx_perr_o", {7'd0, rx_perr}, {7'd0, m_perr_out});
    if (tx_irq) n_txirq++;
    if (rx_irq) n_rxirq++;
    if (!rst_n) begin
      m_hold_full = 0; m_tx_act = 0; m_rx_act = 0; m_nack = 0; m_txirq = 0;
      m_rxirq = 0; m_valid = 0; m_perr = 0; m_perr_out = 0; m_hold = 0;
      m_frame = 0; m_bits = 0; m_rdata = 0; lh = 4'hF; m_t = 0; m_r = 0;
    end else begin
      b = 16 * (int'(div) + 1);
      h = 8 * (int'(div) + 1);
      old_tx = m_tx_act; old_rx = m_rx_act; old_hold = m_hold_full;
      lh = {lh[2:0], line};
      m_txirq = 0; m_rxirq = 0; nset = 0; done_r = 0;
      rxs = !old_rx && !old_tx && !lh[2] && lh[3];
      txs = !old_tx && old_hold && !old_rx && !rxs;
      if (old_tx) begin
        m_t++;
        if (m_t == 10 * b + h && !lh[2]) nset = 1;
        if (m_t == 11 * b) begin m_tx_act = 0; m_txirq = 1; end
      end
      if (txs) begin m_tx_act = 1; m_t = 0; m_frame = m_hold; m_hold_full = 0; end
      if (tx_we && !old_hold) begin m_hold_full = 1; m_hold = tx_data; end
      if (nack_clr) m_nack = 0;
      if (nset) m_nack = 1;
      if (old_rx) begin
        m_r++;
        if (m_r >= h && (m_r - h) % b == 0 && (m_r - h) / b <= 9) begin
          k = (m_r - h) / b;
          if (k == 0) begin
            if (lh[2]) m_rx_act = 0;
          end else if (k <= 8) m_bits[k-1] = lh[2];
          else m_perr = (^m_bits) ^ lh[2];
        end
        if (m_r == 11 * b) begin
          m_rx_act = 0; done_r = 1; m_rdata = m_bits; m_perr_out = m_perr; m_rxirq = 1;
        end
      end
      if (rxs) begin m_rx_act = 1; m_r = 0; m_perr = 0; end
      if (done_r) m_valid = 1;
      else if (rx_ack) m_valid = 0;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 tx_data = d; tx_we = 1'b1;
    @(posedge clk); #1 tx_we = 1'b0;
  endtask

  task automatic clear_nack();
    @(posedge clk); #1 nack_clr = 1'b1;
    @(posedge clk); #1 nack_clr = 1'b0;
    chk("R5 nack cleared", {7'd0, nack}, 8'd0);
  endtask

  task automatic ack_rx();
    @(posedge clk); #1 rx_ack = 1'b1;
    @(posedge clk); #1 rx_ack = 1'b0;
    chk("R7 valid cleared by ack", {7'd0, rx_valid}, 8'd0);
  endtask

  // send through the block; the card model captures slot mids and may reject
  task automatic tx_frame(input logic [7:0] d, input logic nak);
    int b;
    logic [9:0] bits;
    b = 16 * (int'(div) + 1);
    wr(d);
    @(posedge clk);
    for (int k = 0; k < 10; k++) begin
      repeat (b / 2) @(posedge clk);
      #1 bits[k] = line;
      repeat (b - b / 2) @(posedge clk);
    end
    #1 card_pd = nak;
    repeat (b - 4) @(posedge clk);
    #1 card_pd = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R4 tx_irq at 11 bit times", {7'd0, tx_irq}, 8'd1);
    chk("R1 start slot low", {7'd0, bits[0]}, 8'd0);
    chk("R1 data lsb first", bits[8:1], d);
    chk("R2 even parity slot", {7'd0, bits[9]}, {7'd0, ^d});
    repeat (3) @(posedge clk);
    #1 chk("R5 nack after stop sample", {7'd0, nack}, {7'd0, nak});
  endtask

  // card sends a frame toward the block
  task automatic card_send(input logic [7:0] d, input logic bad);
    int b;
    logic [10:0] f;
    b = 16 * (int'(div) + 1);
    f = {1'b1, (^d) ^ bad, d, 1'b0};
    @(posedge clk); #1;
    for (int k = 0; k < 10; k++) begin
      card_pd = !f[k];
      repeat (b) @(posedge clk);
      #1;
    end
    card_pd = 1'b0;
    repeat (b / 2) @(posedge clk);
    #1 chk("R8 error pull-down in stop slot", {7'd0, line}, {7'd0, !bad});
    repeat (b / 2 + 8) @(posedge clk);
    #1 chk("R7 byte valid", {7'd0, rx_valid}, 8'd1);
    chk("R7 received byte", rx_data, d);
    chk("R8 parity flag", {7'd0, rx_perr}, {7'd0, bad});
    ack_rx();
  endtask

  initial begin : stim
    int t0, r0;
    rst_n = 1'b0; div = 8'd1; tx_data = '0; tx_we = 0; nack_clr = 0; rx_ack = 0; card_pd = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset line_pd_o", {7'd0, line_pd}, 8'd0);
    chk("R10 reset tx_ready_o", {7'd0, tx_ready}, 8'd1);
    chk("R10 reset tx_idle_o", {7'd0, tx_idle}, 8'd1);
    chk("R10 reset flags", {4'd0, nack, rx_valid, rx_perr, rx_irq}, 8'd0);
    chk("R10 reset rx_data_o", rx_data, 8'd0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    tx_frame(8'hA5, 1'b0);
    tx_frame(8'h3C, 1'b1);
    clear_nack();

    // R3: third write lands while holding register is full
    t0 = n_txirq;
    wr(8'h11); wr(8'h22); wr(8'h33);
    #1 chk("R3 ready low while holding", {7'd0, tx_ready}, 8'd0);
    repeat (2 * 11 * 32 + 20) @(posedge clk);
    #1 chk("R3 dropped write sends nothing", 8'(n_txirq - t0), 8'd2);
    chk("R3 idle after drain", {7'd0, tx_idle}, 8'd1);

    card_send(8'h96, 1'b0);
    card_send(8'h5A, 1'b1);

    // R6: short low pulse is a false start
    r0 = n_rxirq;
    @(posedge clk); #1 card_pd = 1'b1;
    repeat (4) @(posedge clk);
    #1 card_pd = 1'b0;
    repeat (12 * 32) @(posedge clk);
    #1 chk("R6 glitch gives no byte", 8'(n_rxirq - r0), 8'd0);
    chk("R6 valid stays low", {7'd0, rx_valid}, 8'd0);

    // R9: write during reception waits, own frame not received
    r0 = n_rxirq; t0 = n_txirq;
    fork
      card_send(8'hC3, 1'b0);
      begin repeat (40) @(posedge clk); wr(8'h81); end
    join
    repeat (12 * 32) @(posedge clk);
    #1 chk("R9 own frame not received", 8'(n_rxirq - r0), 8'd1);
    chk("R9 held write sent after rx", 8'(n_txirq - t0), 8'd1);

    div = 8'd0;
    tx_frame(8'h01, 1'b0);
    div = 8'd3;
    tx_frame(8'hFE, 1'b1);
    clear_nack();
    div = 8'd2;
    card_send(8'h7E, 1'b1);

    repeat (10) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule